// File: doc/BRIEF.md
# Two-Level Direct Longest-Prefix Lookup Engine

This block finds the next hop for a destination address by longest-prefix match, without any search. The address splits into a high index and a low index. The high index selects one entry of a first-level table. That entry is one of three things: empty, a next hop that applies to every low-index value, or a pointer to a small second-level block. When it is a pointer, the low index selects an entry inside that block. Prefixes that are no longer than the high index are expanded by host software into every first-level entry they cover. Longer prefixes get a second-level block. The block is seeded with whatever the shorter route gave, and the longer prefix is then expanded inside it.

Lookups arrive on a valid/ready request port. Every cycle can accept a new request. The result comes out exactly two cycles later and in request order. After reset, a small state machine wipes both tables, one entry per cycle. The wipe runs in state `ST_WIPE`. When the counter reaches the last entry, the machine takes the transition `wipe_done` to state `ST_LIVE`. It stays there until the next reset. Requests and table writes are only taken in `ST_LIVE`.

The index widths are parameters. With full-size addresses the split is 24 high bits and 8 low bits. The defaults shrink it to 10 and 4 so that the on-chip arrays stay small. The behaviour is the same at every setting.

Top module: `lpm_direct_lookup`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly max(2^L1_W, NBLK*2^L2_W) cycles while the tables are wiped. It then stays high until the next reset, and every entry reads as empty.
- R2: A table write presented while `req_ready` is low is discarded and leaves no trace in later lookups.
- R3: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Each accepted request yields exactly one result with `res_valid` high two cycles later. Back-to-back requests give back-to-back results, in request order. No result appears for a cycle without an accepted request.
- R4: When the first-level entry selected by address bits [ADDR_W-1:L2_W] is empty, the result is a miss (`res_hit`=0, `res_nh`=0) for every value of the low bits.
- R5: A first-level write uses `wr_level`=0, with `wr_index`[L1_W-1:0] equal to the high address bits, `wr_route`=1, `wr_link`=0 and the next hop in `wr_value`. Afterwards every address with those high bits hits with that next hop, whatever its low bits.
- R6: A first-level write with `wr_route`=1 and `wr_link`=1 makes `wr_value`[BLK_W-1:0] a block number. The result then comes from the second-level entry at index {block, address bits [L2_W-1:0]}. That entry is written with `wr_level`=1, `wr_index` = {block, low bits}, `wr_route` and `wr_value`[NH_W-1:0]. An empty second-level entry gives a miss.
- R7: Host software writes prefixes in ascending length, expands each one over the entries it covers, and seeds each new block from its first-level entry. After that, every address returns the next hop of the longest matching prefix, including nested and overlapping prefixes, or a miss when none matches.
- R8: A write takes effect for every lookup presented in any cycle after the write cycle.
- R9: `res_hit` and `res_nh` are zero whenever `res_valid` is low, and `res_nh` is zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine accepts requests (wipe finished) |
| req_addr | input | ADDR_W | Destination address to look up |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | A route matched |
| res_nh | output | NH_W | Next hop of the longest matching prefix |
| wr_en | input | 1 | Table write strobe |
| wr_level | input | 1 | 0 = first-level table, 1 = second-level table |
| wr_index | input | IDX_W | Entry index within the selected table |
| wr_route | input | 1 | 1 = entry holds a route or pointer, 0 = empty |
| wr_link | input | 1 | First level only: 1 = `wr_value` is a block number |
| wr_value | input | VAL_W | Next hop or block number |

## Verification
The bench sweeps every address of the default configuration twice. The first sweep runs on the wiped table, where a wipe that left stale entries, or a write slipping in during the wipe, would surface as hits. The second sweep runs after host-style expansion of nested prefixes that overlap at many lengths. An engine that confused the pointer flag, indexed the wrong block, or let a short prefix overwrite a longer one would return the wrong next hop at the edges of the nested ranges. A gapped request pattern and a write followed at once by a lookup catch a pipeline that drifts out of order, repeats results, or reads a stale entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [0:0] {
        ST_WIPE = 1'b0,
        ST_LIVE = 1'b1
    } lpm_state_e;

    localparam logic LVL_FIRST  = 1'b0;
    localparam logic LVL_SECOND = 1'b1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpm_wipe_ctrl.sv
module lpm_wipe_ctrl
    import lpm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             live,
    output logic             wipe_en,
    output logic [CNT_W-1:0] wipe_idx
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DEPTH - 1);

    lpm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WIPE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: wipe_done moves ST_WIPE to ST_LIVE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WIPE: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_IDX) begin
                    state_d = ST_LIVE;
                end
            end
            ST_LIVE: begin
                state_d = ST_LIVE;
            end
            default: state_d = ST_WIPE;
        endcase
    end

    // outputs
    always_comb begin
        live    = 1'b0;
        wipe_en = 1'b0;
        unique case (state_q)
            ST_WIPE: wipe_en = 1'b1;
            ST_LIVE: live    = 1'b1;
            default: wipe_en = 1'b1;
        endcase
    end

    assign wipe_idx = cnt_q;

endmodule

// File: rtl/lpm_first_stage.sv
module lpm_first_stage #(
    parameter int L1_W  = 10,
    parameter int L2_W  = 4,
    parameter int VAL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wipe_en,
    input  logic [L1_W-1:0]       wipe_idx,
    input  logic                  wr_en,
    input  logic [L1_W-1:0]       wr_idx,
    input  logic                  wr_route,
    input  logic                  wr_link,
    input  logic [VAL_W-1:0]      wr_value,
    input  logic                  req_fire,
    input  logic [L1_W+L2_W-1:0]  req_addr,
    output logic                  s1_valid,
    output logic                  s1_route,
    output logic                  s1_link,
    output logic [VAL_W-1:0]      s1_value,
    output logic [L2_W-1:0]       s1_low
);

    localparam int DEPTH  = 2 ** L1_W;
    localparam int ADDR_W = L1_W + L2_W;

    typedef struct packed {
        logic             route;
        logic             link;
        logic [VAL_W-1:0] value;
    } top_ent_t;

    top_ent_t tbl [DEPTH];
    top_ent_t rd_q;

    // table storage: the wipe has priority over host writes
    always_ff @(posedge clk) begin
        if (wipe_en) begin
            tbl[wipe_idx] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= '{route: wr_route, link: wr_link, value: wr_value};
        end
    end

    // first pipeline register: directly indexed read by the high bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            rd_q     <= '0;
            s1_low   <= '0;
        end else begin
            s1_valid <= req_fire;
            if (req_fire) begin
                rd_q   <= tbl[req_addr[ADDR_W-1:L2_W]];
                s1_low <= req_addr[L2_W-1:0];
            end
        end
    end

    assign s1_route = rd_q.route;
    assign s1_link  = rd_q.link;
    assign s1_value = rd_q.value;

endmodule

// File: rtl/lpm_second_stage.sv
module lpm_second_stage #(
    parameter int L2_W  = 4,
    parameter int BLK_W = 3,
    parameter int NH_W  = 8,
    parameter int VAL_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wipe_en,
    input  logic [BLK_W+L2_W-1:0]  wipe_idx,
    input  logic                   wr_en,
    input  logic [BLK_W+L2_W-1:0]  wr_idx,
    input  logic                   wr_route,
    input  logic [NH_W-1:0]        wr_nh,
    input  logic                   s1_valid,
    input  logic                   s1_route,
    input  logic                   s1_link,
    input  logic [VAL_W-1:0]       s1_value,
    input  logic [L2_W-1:0]        s1_low,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [NH_W-1:0]        res_nh
);

    localparam int IDX2_W = BLK_W + L2_W;
    localparam int DEPTH  = 2 ** IDX2_W;

    typedef struct packed {
        logic            route;
        logic [NH_W-1:0] nh;
    } leaf_ent_t;

    leaf_ent_t         tbl [DEPTH];
    leaf_ent_t         rd_ent;
    logic [IDX2_W-1:0] rd_addr;
    logic              hit_d;
    logic [NH_W-1:0]   nh_d;

    always_ff @(posedge clk) begin
        if (wipe_en) begin
            tbl[wipe_idx] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= '{route: wr_route, nh: wr_nh};
        end
    end

    // block number from the first level, low address bits within the block
    assign rd_addr = {s1_value[BLK_W-1:0], s1_low};
    assign rd_ent  = tbl[rd_addr];

    always_comb begin
        if (s1_link) begin
            hit_d = rd_ent.route;
            nh_d  = rd_ent.nh;
        end else begin
            hit_d = s1_route;
            nh_d  = s1_value[NH_W-1:0];
        end
        if (!s1_valid || !hit_d) begin
            hit_d = 1'b0;
            nh_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_nh    <= '0;
        end else begin
            res_valid <= s1_valid;
            res_hit   <= hit_d;
            res_nh    <= nh_d;
        end
    end

endmodule

// File: rtl/lpm_direct_lookup.sv
module lpm_direct_lookup
    import lpm_pkg::*;
#(
    parameter int L1_W  = 10,
    parameter int L2_W  = 4,
    parameter int NH_W  = 8,
    parameter int NBLK  = 8,
    localparam int BLK_W  = $clog2(NBLK),
    localparam int ADDR_W = L1_W + L2_W,
    localparam int IDX_W  = imax(L1_W, BLK_W + L2_W),
    localparam int VAL_W  = imax(NH_W, BLK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [NH_W-1:0]   res_nh,
    input  logic              wr_en,
    input  logic              wr_level,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_route,
    input  logic              wr_link,
    input  logic [VAL_W-1:0]  wr_value
);

    localparam int IDX2_W     = BLK_W + L2_W;
    localparam int WIPE_DEPTH = imax(2 ** L1_W, NBLK * (2 ** L2_W));
    localparam int CNT_W      = $clog2(WIPE_DEPTH);

    logic             live;
    logic             wipe_en;
    logic [CNT_W-1:0] wipe_idx;
    logic             req_fire;
    logic             top_we;
    logic             leaf_we;
    logic             s1_valid;
    logic             s1_route;
    logic             s1_link;
    logic [VAL_W-1:0] s1_value;
    logic [L2_W-1:0]  s1_low;

    assign req_ready = live;
    assign req_fire  = req_valid && live;
    assign top_we    = wr_en && live && (wr_level == LVL_FIRST);
    assign leaf_we   = wr_en && live && (wr_level == LVL_SECOND);

    lpm_wipe_ctrl #(
        .DEPTH (WIPE_DEPTH),
        .CNT_W (CNT_W)
    ) u_wipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .wipe_en  (wipe_en),
        .wipe_idx (wipe_idx)
    );

    lpm_first_stage #(
        .L1_W  (L1_W),
        .L2_W  (L2_W),
        .VAL_W (VAL_W)
    ) u_first (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe_en  (wipe_en),
        .wipe_idx (wipe_idx[L1_W-1:0]),
        .wr_en    (top_we),
        .wr_idx   (wr_index[L1_W-1:0]),
        .wr_route (wr_route),
        .wr_link  (wr_link),
        .wr_value (wr_value),
        .req_fire (req_fire),
        .req_addr (req_addr),
        .s1_valid (s1_valid),
        .s1_route (s1_route),
        .s1_link  (s1_link),
        .s1_value (s1_value),
        .s1_low   (s1_low)
    );

    lpm_second_stage #(
        .L2_W  (L2_W),
        .BLK_W (BLK_W),
        .NH_W  (NH_W),
        .VAL_W (VAL_W)
    ) u_second (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_en   (wipe_en),
        .wipe_idx  (wipe_idx[IDX2_W-1:0]),
        .wr_en     (leaf_we),
        .wr_idx    (wr_index[IDX2_W-1:0]),
        .wr_route  (wr_route),
        .wr_nh     (wr_value[NH_W-1:0]),
        .s1_valid  (s1_valid),
        .s1_route  (s1_route),
        .s1_link   (s1_link),
        .s1_value  (s1_value),
        .s1_low    (s1_low),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_nh    (res_nh)
    );

endmodule

// File: rtl/lpm_direct_lookup_chk.sv
module lpm_direct_lookup_chk
    import lpm_pkg::*;
#(
    parameter int L1_W = 10,
    parameter int L2_W = 4,
    parameter int NH_W = 8,
    parameter int NBLK = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            res_valid,
    input logic            res_hit,
    input logic [NH_W-1:0] res_nh
);

    localparam int WIPE_DEPTH = imax(2 ** L1_W, NBLK * (2 ** L2_W));

    int since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
        end else if (since_q < WIPE_DEPTH) begin
            since_q <= since_q + 1;
        end
    end

    // R1
    wipe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < WIPE_DEPTH) |-> !req_ready);

    // R1
    live_after_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= WIPE_DEPTH) |-> req_ready);

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 res_valid);

    // R3
    no_phantom_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req_valid && req_ready, 2));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && (res_nh == '0)));

    // R9
    miss_zero_nh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_nh == '0));

endmodule

bind lpm_direct_lookup lpm_direct_lookup_chk #(
    .L1_W (L1_W),
    .L2_W (L2_W),
    .NH_W (NH_W),
    .NBLK (NBLK)
) u_chk (.*);

// File: tb/lpm_direct_lookup_test.sv
module lpm_direct_lookup_test;

    localparam int L1_W   = 10;
    localparam int L2_W   = 4;
    localparam int NH_W   = 8;
    localparam int NBLK   = 8;
    localparam int ADDR_W = L1_W + L2_W;
    localparam int IDX_W  = 10;
    localparam int VAL_W  = 8;
    localparam int WIPE_DEPTH = (2 ** L1_W > NBLK * (2 ** L2_W)) ? 2 ** L1_W : NBLK * (2 ** L2_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              res_valid;
    logic              res_hit;
    logic [NH_W-1:0]   res_nh;
    logic              wr_en = 1'b0;
    logic              wr_level = 1'b0;
    logic [IDX_W-1:0]  wr_index = '0;
    logic              wr_route = 1'b0;
    logic              wr_link = 1'b0;
    logic [VAL_W-1:0]  wr_value = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lpm_direct_lookup #(
        .L1_W (L1_W), .L2_W (L2_W), .NH_W (NH_W), .NBLK (NBLK)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .res_valid (res_valid), .res_hit (res_hit), .res_nh (res_nh),
        .wr_en (wr_en), .wr_level (wr_level), .wr_index (wr_index),
        .wr_route (wr_route), .wr_link (wr_link), .wr_value (wr_value)
    );

    // software route list, ascending prefix length
    logic [ADDR_W-1:0] pfx_val [16];
    int                pfx_len [16];
    logic [NH_W-1:0]   pfx_nh  [16];
    int                n_pfx = 0;
    int                n_active = 0;

    // host shadow of the first-level table
    bit              sh_route [2 ** L1_W];
    bit              sh_link  [2 ** L1_W];
    logic [VAL_W-1:0] sh_val  [2 ** L1_W];
    int              next_blk = 0;

    // expected-result pipeline, two deep
    bit              sl_v [2];
    bit              sl_h [2];
    logic [NH_W-1:0] sl_n [2];
    string           sl_t [2];

    task automatic add_pfx(input logic [ADDR_W-1:0] v, input int len, input logic [NH_W-1:0] nh);
        pfx_val[n_pfx] = v;
        pfx_len[n_pfx] = len;
        pfx_nh[n_pfx]  = nh;
        n_pfx++;
    endtask

    task automatic ref_lookup(input logic [ADDR_W-1:0] a, output bit hit, output logic [NH_W-1:0] nh);
        int best = -1;
        hit = 1'b0;
        nh  = '0;
        for (int i = 0; i < n_active; i++) begin
            int sh = ADDR_W - pfx_len[i];
            if ((a >> sh) == (pfx_val[i] >> sh) && pfx_len[i] > best) begin
                best = pfx_len[i];
                hit  = 1'b1;
                nh   = pfx_nh[i];
            end
        end
    endtask

    task automatic fail_line(input string tag, input string what, input int act, input int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // one clock: check the result due now, then drive request and write
    task automatic cyc(input bit lv, input logic [ADDR_W-1:0] a, input string tag,
                       input bit we = 1'b0, input bit lvl = 1'b0,
                       input logic [IDX_W-1:0] idx = '0, input bit rt = 1'b0,
                       input bit lk = 1'b0, input logic [VAL_W-1:0] v = '0);
        bit              eh;
        logic [NH_W-1:0] en;
        @(negedge clk);
        n_cmp++;
        if (sl_v[1]) begin
            if (res_valid !== 1'b1) fail_line(sl_t[1], "res_valid", int'(res_valid), 1);
            else if (res_hit !== sl_h[1]) fail_line(sl_t[1], "res_hit", int'(res_hit), int'(sl_h[1]));
            else if (res_nh !== sl_n[1]) fail_line(sl_t[1], "res_nh", int'(res_nh), int'(sl_n[1]));
        end else begin
            if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_nh !== '0)
                fail_line("R9", "idle outputs", int'({res_valid, res_hit, res_nh}), 0);
        end
        ref_lookup(a, eh, en);
        sl_v[1] = sl_v[0]; sl_h[1] = sl_h[0]; sl_n[1] = sl_n[0]; sl_t[1] = sl_t[0];
        sl_v[0] = lv && req_ready;
        sl_h[0] = eh; sl_n[0] = en; sl_t[0] = tag;
        req_valid = lv;  req_addr = a;
        wr_en = we; wr_level = lvl; wr_index = idx;
        wr_route = rt; wr_link = lk; wr_value = v;
    endtask

    task automatic wr_top(input logic [IDX_W-1:0] idx, input bit rt, input bit lk, input logic [VAL_W-1:0] v);
        cyc(1'b0, '0, "R8", 1'b1, 1'b0, idx, rt, lk, v);
    endtask

    task automatic wr_leaf(input logic [IDX_W-1:0] idx, input bit rt, input logic [VAL_W-1:0] v);
        cyc(1'b0, '0, "R8", 1'b1, 1'b1, idx, rt, 1'b0, v);
    endtask

    // host-side expansion of the route list into both tables
    task automatic program_routes();
        for (int p = 0; p < n_pfx; p++) begin
            int len = pfx_len[p];
            if (len <= L1_W) begin
                int base = int'(pfx_val[p] >> L2_W) & ~((1 << (L1_W - len)) - 1);
                for (int j = 0; j < (1 << (L1_W - len)); j++) begin
                    wr_top(IDX_W'(base + j), 1'b1, 1'b0, VAL_W'(pfx_nh[p]));
                    sh_route[base + j] = 1'b1;
                    sh_link[base + j]  = 1'b0;
                    sh_val[base + j]   = VAL_W'(pfx_nh[p]);
                end
            end else begin
                int top = int'(pfx_val[p] >> L2_W);
                int blk;
                int lob;
                if (!sh_link[top]) begin
                    blk = next_blk++;
                    for (int j = 0; j < (1 << L2_W); j++)
                        wr_leaf(IDX_W'(blk * (1 << L2_W) + j), sh_route[top], sh_val[top]);
                    wr_top(IDX_W'(top), 1'b1, 1'b1, VAL_W'(blk));
                    sh_route[top] = 1'b1;
                    sh_link[top]  = 1'b1;
                    sh_val[top]   = VAL_W'(blk);
                end
                blk = int'(sh_val[top]);
                lob = int'(pfx_val[p][L2_W-1:0]) & ~((1 << (ADDR_W - len)) - 1);
                for (int j = 0; j < (1 << (ADDR_W - len)); j++)
                    wr_leaf(IDX_W'(blk * (1 << L2_W) + lob + j), 1'b1, VAL_W'(pfx_nh[p]));
            end
        end
    endtask

    function automatic string sweep_tag(input logic [ADDR_W-1:0] a);
        logic [L1_W-1:0] t = a[ADDR_W-1:L2_W];
        if (t == 10'b1011100110 || t == 10'b0000011111) return "R6";
        if (t == 10'b1100000000) return "R5";
        return "R7";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int wipe_cycles = 0;
        for (int i = 0; i < 2; i++) begin
            sl_v[i] = 1'b0; sl_h[i] = 1'b0; sl_n[i] = '0; sl_t[i] = "R9";
        end
        for (int i = 0; i < 2 ** L1_W; i++) begin
            sh_route[i] = 1'b0; sh_link[i] = 1'b0; sh_val[i] = '0;
        end
        // nested and overlapping routes, lengths 1 to 14
        add_pfx(14'b0_0000000000000, 1, 8'd7);
        add_pfx(14'b11_000000000000, 2, 8'd10);
        add_pfx(14'b101_00000000000, 3, 8'd1);
        add_pfx(14'b101110_00000000, 6, 8'd2);
        add_pfx(14'b10111001_000000, 8, 8'd3);
        add_pfx(14'b1011100110_0000, 10, 8'd4);
        add_pfx(14'b1100000000_0000, 10, 8'd9);
        add_pfx(14'b00000111111_000, 11, 8'd8);
        add_pfx(14'b101110011011_00, 12, 8'd5);
        add_pfx(14'b10111001101101, 14, 8'd6);

        // reset state (R1)
        repeat (4) @(negedge clk);
        n_cmp++;
        if (req_ready !== 1'b0 || res_valid !== 1'b0)
            fail_line("R1", "reset outputs", int'({req_ready, res_valid}), 0);
        rst_n = 1'b1;

        // wipe length (R1); a write during the wipe must vanish (R2)
        do begin
            if (wipe_cycles == 20)
                cyc(1'b0, '0, "R2", 1'b1, 1'b0, IDX_W'(5), 1'b1, 1'b0, 8'h77);
            else
                cyc(1'b0, '0, "R1");
            wipe_cycles++;
        end while (!req_ready && wipe_cycles < 5000);
        n_cmp++;
        if (wipe_cycles != WIPE_DEPTH)
            fail_line("R1", "wipe cycles", wipe_cycles, WIPE_DEPTH);

        // empty table, every address, back to back (R4, R2, R3)
        for (int a = 0; a < 2 ** ADDR_W; a++)
            cyc(1'b1, ADDR_W'(a), ((a >> L2_W) == 5) ? "R2" : "R4");
        cyc(1'b0, '0, "R3");
        cyc(1'b0, '0, "R3");

        // host expansion, then every address against the reference (R5, R6, R7)
        program_routes();
        n_active = n_pfx;
        cyc(1'b0, '0, "R3");
        for (int a = 0; a < 2 ** ADDR_W; a++)
            cyc(1'b1, ADDR_W'(a), sweep_tag(ADDR_W'(a)));

        // gapped requests keep order and count (R3)
        for (int i = 0; i < 90; i++)
            cyc((i % 3) == 0, ADDR_W'(16'h2E60 + i * 7), "R3");
        cyc(1'b0, '0, "R3");
        cyc(1'b0, '0, "R3");

        // write then look up on the very next cycle (R8)
        add_pfx(14'b1000000000_0000, 10, 8'h55);
        n_active = n_pfx;
        wr_top(IDX_W'(10'b1000000000), 1'b1, 1'b0, 8'h55);
        cyc(1'b1, 14'b1000000000_0011, "R8");
        cyc(1'b1, 14'b1000000001_0000, "R8");
        cyc(1'b1, 14'b1000000000_1111, "R8");
        cyc(1'b0, '0, "R3");
        cyc(1'b0, '0, "R3");
        cyc(1'b0, '0, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule